// File: doc/BRIEF.md
# Hierarchical SRAM Address Scrambler

This block turns a logical memory address into the physical row and column position of the cell it reaches. The array is modelled as built by repeated halving. Each address bit belongs to either the row group or the column group, and inside its group it holds a rank that sets its place by geometric weight. Rank 0 is the finest split. Each bit also selects how its two halves relate. In a mirror bit the half for 1 is the reflection of the half for 0 about their shared boundary. In a shift bit the half for 1 is a plain translated copy.

A small write port loads the per-bit configuration. The register set is checked all the time, and an error flag rises whenever the setting does not describe a legal map. A translation request comes as a strobe with an address and a data-block number. Each data bit owns whole columns, so the block number forms the high part of the physical column. The result appears one clock later together with a valid pulse. The block serves test-pattern generators and failure-location logic that must know which cells are physical neighbours.

Top module: `scr_map_top`

## Requirements
- R1: While reset is held, and on the first edge after it, out_valid is 0, out_row, out_col and out_blk are 0, and cfg_err is 0.
- R2: The reset configuration places logical bits [COL_BITS-1:0] in the column group with rank equal to their bit position. It places the remaining bits in the row group with rank equal to bit position minus COL_BITS. All bits are shift bits, so the row index equals the upper address bits and the local column equals the lower ones.
- R3: The physical row index bit r comes from the row-group bit of rank r, and the local column bit r comes from the column-group bit of rank r. Mirror corrections from R4 apply on top of this.
- R4: When a mirror bit is 1, every lower-ranked bit of the same group is inverted before it is placed. Bits of the other group are not affected.
- R5: A shift bit that is 1 leaves the lower-ranked bits of its group unchanged.
- R6: out_blk equals the in_blk of the request. out_col is {in_blk, local column}, so the block number is the top BLK_W bits of the column.
- R7: The outputs update on the clock edge that samples in_valid=1, and out_valid is 1 for exactly that following cycle. When in_valid is 0 the outputs hold and out_valid is 0.
- R8: cfg_err is 1 whenever the number of row-group bits differs from ROW_BITS, or any rank of a group is held by zero or by more than one bit of that group. Otherwise cfg_err is 0.
- R9: A write with cfg_we=1 loads group (cfg_row: 1=row, 0=column), rank and mirror flag into entry cfg_idx. A write with cfg_idx >= ADDR_W changes nothing.
- R10: Under any legal configuration, logical address 0 maps to row 0 and local column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | IDX_W | Address bit whose entry is written |
| cfg_row | input | 1 | 1 = row group, 0 = column group |
| cfg_rank | input | RANK_W | Rank inside the group (0 = finest) |
| cfg_mirror | input | 1 | 1 = mirror bit, 0 = shift bit |
| cfg_err | output | 1 | Configuration does not form a legal map |
| in_valid | input | 1 | Translation request strobe |
| in_addr | input | ADDR_W | Logical address |
| in_blk | input | BLK_W | Data-block number |
| out_valid | output | 1 | Result valid pulse |
| out_row | output | ROW_BITS | Physical row index |
| out_col | output | COL_BITS+BLK_W | Physical column index |
| out_blk | output | BLK_W | Data-block number of the result |

## Verification
The bench uses the defaults: ADDR_W=6 with ROW_BITS=3, which gives three bits per group, BLK_W=2, and the registered output. With three ranks in each group, a mirror bit can be placed at the top rank and at a middle rank, so nested inversion is seen. A shift bit can sit between mirror bits. A six-entry register file also leaves index values 6 and 7 free to test the ignored write. With two block bits, nonzero block numbers can be confirmed in the top column field.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic {
      GRP_COL = 1'b0,
      GRP_ROW = 1'b1
   } grp_e;
endpackage

// File: rtl/scr_cfg_regs.sv
module scr_cfg_regs
   import scr_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int ROW_BITS = 3,
   parameter int RANK_W   = 3,
   parameter int IDX_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IDX_W-1:0]               idx,
   input  logic                           row_sel,
   input  logic [RANK_W-1:0]              rank,
   input  logic                           mirror,
   output logic [ADDR_W-1:0]              grp_row,
   output logic [ADDR_W-1:0][RANK_W-1:0]  rank_tab,
   output logic [ADDR_W-1:0]              mir_tab,
   output logic                           bad
);
   localparam int COL_BITS = ADDR_W - ROW_BITS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ADDR_W; i++) begin
            grp_row[i]  <= (i >= COL_BITS) ? GRP_ROW : GRP_COL;
            rank_tab[i] <= (i >= COL_BITS) ? RANK_W'(i - COL_BITS) : RANK_W'(i);
            mir_tab[i]  <= 1'b0;
         end
      end else if (we && (int'(idx) < ADDR_W)) begin
         grp_row[idx]  <= row_sel;
         rank_tab[idx] <= rank;
         mir_tab[idx]  <= mirror;
      end
   end

   // Legality: correct group sizes and each rank of each group owned once.
   always_comb begin
      int n_row;
      int hit_row;
      int hit_col;
      bad   = 1'b0;
      n_row = 0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (grp_row[i]) n_row++;
      end
      if (n_row != ROW_BITS) bad = 1'b1;
      for (int r = 0; r < ADDR_W; r++) begin
         hit_row = 0;
         hit_col = 0;
         for (int i = 0; i < ADDR_W; i++) begin
            if (rank_tab[i] == RANK_W'(r)) begin
               if (grp_row[i]) hit_row++;
               else            hit_col++;
            end
         end
         if ((r < ROW_BITS) && (hit_row != 1)) bad = 1'b1;
         if ((r < COL_BITS) && (hit_col != 1)) bad = 1'b1;
      end
   end
endmodule

// File: rtl/scr_group_map.sv
module scr_group_map #(
   parameter int   ADDR_W  = 6,
   parameter int   N_OUT   = 3,
   parameter int   RANK_W  = 3,
   parameter logic GRP_SEL = 1'b1
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [ADDR_W-1:0]              grp_row,
   input  logic [ADDR_W-1:0][RANK_W-1:0]  rank_tab,
   input  logic [ADDR_W-1:0]              mir_tab,
   output logic [N_OUT-1:0]               idx
);
   logic [N_OUT-1:0] sel_bit;
   logic [N_OUT-1:0] sel_mir;

   // Gather the address bit and mirror flag that own each rank.
   always_comb begin
      for (int r = 0; r < N_OUT; r++) begin
         sel_bit[r] = 1'b0;
         sel_mir[r] = 1'b0;
         for (int i = 0; i < ADDR_W; i++) begin
            if ((grp_row[i] == GRP_SEL) && (rank_tab[i] == RANK_W'(r))) begin
               sel_bit[r] = sel_bit[r] | addr[i];
               sel_mir[r] = sel_mir[r] | mir_tab[i];
            end
         end
      end
   end

   // Walk from the coarsest rank down; a set mirror bit inverts all finer ranks.
   always_comb begin
      logic flip;
      flip = 1'b0;
      for (int r = N_OUT - 1; r >= 0; r--) begin
         idx[r] = sel_bit[r] ^ flip;
         flip   = flip ^ (sel_bit[r] & sel_mir[r]);
      end
   end
endmodule

// File: rtl/scr_map_top.sv
module scr_map_top
   import scr_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int ROW_BITS = 3,
   parameter int BLK_W    = 2,
   parameter bit REG_OUT  = 1'b1,
   localparam int COL_BITS = ADDR_W - ROW_BITS,
   localparam int RANK_W   = (ADDR_W > 2) ? $clog2(ADDR_W) : 1,
   localparam int IDX_W    = RANK_W,
   localparam int COL_W    = COL_BITS + BLK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic                cfg_row,
   input  logic [RANK_W-1:0]   cfg_rank,
   input  logic                cfg_mirror,
   output logic                cfg_err,
   input  logic                in_valid,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [BLK_W-1:0]    in_blk,
   output logic                out_valid,
   output logic [ROW_BITS-1:0] out_row,
   output logic [COL_W-1:0]    out_col,
   output logic [BLK_W-1:0]    out_blk
);
   if (ADDR_W < 2 || ROW_BITS < 1 || ROW_BITS >= ADDR_W || BLK_W < 1) begin : g_bad_params
      $error("scr_map_top: illegal parameter set");
   end

   logic [ADDR_W-1:0]             grp_row;
   logic [ADDR_W-1:0][RANK_W-1:0] rank_tab;
   logic [ADDR_W-1:0]             mir_tab;
   logic [ROW_BITS-1:0]           row_d;
   logic [COL_BITS-1:0]           col_loc;

   scr_cfg_regs #(
      .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .RANK_W(RANK_W), .IDX_W(IDX_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .row_sel(cfg_row),
      .rank(cfg_rank), .mirror(cfg_mirror), .grp_row(grp_row),
      .rank_tab(rank_tab), .mir_tab(mir_tab), .bad(cfg_err)
   );

   scr_group_map #(
      .ADDR_W(ADDR_W), .N_OUT(ROW_BITS), .RANK_W(RANK_W), .GRP_SEL(GRP_ROW)
   ) u_row_map (
      .addr(in_addr), .grp_row(grp_row), .rank_tab(rank_tab),
      .mir_tab(mir_tab), .idx(row_d)
   );

   scr_group_map #(
      .ADDR_W(ADDR_W), .N_OUT(COL_BITS), .RANK_W(RANK_W), .GRP_SEL(GRP_COL)
   ) u_col_map (
      .addr(in_addr), .grp_row(grp_row), .rank_tab(rank_tab),
      .mir_tab(mir_tab), .idx(col_loc)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
            out_blk   <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_row <= row_d;
               out_col <= {in_blk, col_loc};
               out_blk <= in_blk;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign out_row   = row_d;
      assign out_col   = {in_blk, col_loc};
      assign out_blk   = in_blk;
   end
endmodule

// File: rtl/scr_map_chk.sv
module scr_map_chk #(
   parameter int ADDR_W   = 6,
   parameter int ROW_BITS = 3,
   parameter int BLK_W    = 2,
   parameter bit REG_OUT  = 1'b1,
   localparam int COL_BITS = ADDR_W - ROW_BITS,
   localparam int COL_W    = COL_BITS + BLK_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_err,
   input logic                in_valid,
   input logic [ADDR_W-1:0]   in_addr,
   input logic [BLK_W-1:0]    in_blk,
   input logic                out_valid,
   input logic [ROW_BITS-1:0] out_row,
   input logic [COL_W-1:0]    out_col,
   input logic [BLK_W-1:0]    out_blk
);
   if (REG_OUT) begin : g_chk
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R7
      AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_row) && $stable(out_col) && $stable(out_blk))); // R7
      AST_BLK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_blk == $past(in_blk))); // R6
      AST_BLK_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_col[COL_W-1:COL_BITS] == $past(in_blk))); // R6
      AST_ZERO_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (in_addr == '0) && !cfg_err) |=>
            ((out_row == '0) && (out_col[COL_BITS-1:0] == '0))); // R10
   end
endmodule

bind scr_map_top scr_map_chk #(
   .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .BLK_W(BLK_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .in_valid(in_valid),
   .in_addr(in_addr), .in_blk(in_blk), .out_valid(out_valid),
   .out_row(out_row), .out_col(out_col), .out_blk(out_blk)
);

// File: tb/tb_scr_map_top.sv
module tb_scr_map_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic       cfg_row = 1'b0;
   logic [2:0] cfg_rank = '0;
   logic       cfg_mirror = 1'b0;
   logic       cfg_err;
   logic       in_valid = 1'b0;
   logic [5:0] in_addr = '0;
   logic [1:0] in_blk = '0;
   logic       out_valid;
   logic [2:0] out_row;
   logic [4:0] out_col;
   logic [1:0] out_blk;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   scr_map_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_row(cfg_row), .cfg_rank(cfg_rank), .cfg_mirror(cfg_mirror),
      .cfg_err(cfg_err), .in_valid(in_valid), .in_addr(in_addr),
      .in_blk(in_blk), .out_valid(out_valid), .out_row(out_row),
      .out_col(out_col), .out_blk(out_blk)
   );

   // Entry: {addr[5:0], blk[1:0], row[2:0], col[4:0]} under the scrambled setting
   localparam int NV = 12;
   localparam logic [15:0] VEC [NV] = '{
      {6'h00, 2'd1, 3'd0, 5'd8},
      {6'h01, 2'd0, 3'd7, 5'd0},
      {6'h04, 2'd0, 3'd1, 5'd0},
      {6'h10, 2'd0, 3'd3, 5'd0},
      {6'h11, 2'd0, 3'd4, 5'd0},
      {6'h15, 2'd3, 3'd5, 5'd24},
      {6'h08, 2'd0, 3'd0, 5'd7},
      {6'h20, 2'd2, 3'd0, 5'd18},
      {6'h02, 2'd0, 3'd0, 5'd1},
      {6'h2A, 2'd0, 3'd0, 5'd4},
      {6'h3F, 2'd1, 3'd5, 5'd12},
      {6'h09, 2'd0, 3'd7, 5'd7}
   };

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int idx, input bit row, input int rank, input bit mir);
      @(negedge clk);
      cfg_we     = 1'b1;
      cfg_idx    = 3'(idx);
      cfg_row    = row;
      cfg_rank   = 3'(rank);
      cfg_mirror = mir;
      @(negedge clk);
      cfg_we     = 1'b0;
   endtask

   task automatic translate(input logic [5:0] a, input logic [1:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = a;
      in_blk   = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 out_row", int'(out_row), 0);
      check("R1 out_col", int'(out_col), 0);
      check("R1 cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after release", int'(out_valid), 0);

      // R2: identity map from reset configuration
      translate(6'h2D, 2'd0);
      check("R2 row", int'(out_row), 5);
      check("R2 col", int'(out_col), 5);
      check("R7 valid pulse", int'(out_valid), 1);
      @(negedge clk);
      check("R7 valid drops", int'(out_valid), 0);

      // R9: load scrambled setting
      cfg_write(0, 1'b1, 2, 1'b1);
      cfg_write(1, 1'b0, 0, 1'b0);
      cfg_write(2, 1'b1, 0, 1'b0);
      cfg_write(3, 1'b0, 2, 1'b1);
      cfg_write(4, 1'b1, 1, 1'b1);
      cfg_write(5, 1'b0, 1, 1'b0);
      check("R8 legal setting", int'(cfg_err), 0);

      // R3 R4 R6: table walk
      for (int k = 0; k < NV; k++) begin
         translate(VEC[k][15:10], VEC[k][9:8]);
         check("R3 R4 row", int'(out_row), int'(VEC[k][7:5]));
         check("R3 R4 R6 col", int'(out_col), int'(VEC[k][4:0]));
         check("R6 blk", int'(out_blk), int'(VEC[k][9:8]));
      end

      // R10: address zero
      translate(6'h00, 2'd0);
      check("R10 row", int'(out_row), 0);
      check("R10 col", int'(out_col), 0);

      // R5: shift bit a5 over a1 keeps a1 uninverted
      translate(6'h22, 2'd0);
      check("R5 col", int'(out_col), 3);
      check("R5 row", int'(out_row), 0);

      // R7: idle cycle holds outputs
      @(negedge clk);
      in_addr = 6'h3F;
      in_blk  = 2'd3;
      @(negedge clk);
      check("R7 hold valid", int'(out_valid), 0);
      check("R7 hold col", int'(out_col), 3);
      check("R7 hold blk", int'(out_blk), 0);

      // R9: out-of-range index ignored
      cfg_write(7, 1'b1, 0, 1'b1);
      cfg_write(6, 1'b0, 1, 1'b1);
      check("R9 err after ignored write", int'(cfg_err), 0);
      translate(6'h04, 2'd0);
      check("R9 row unchanged", int'(out_row), 1);
      translate(6'h2A, 2'd0);
      check("R9 col unchanged", int'(out_col), 4);

      // R8: duplicate rank
      cfg_write(2, 1'b1, 2, 1'b0);
      check("R8 duplicate rank", int'(cfg_err), 1);
      cfg_write(2, 1'b1, 0, 1'b0);
      check("R8 restored", int'(cfg_err), 0);
      // R8: group size mismatch
      cfg_write(1, 1'b1, 3, 1'b0);
      check("R8 row count", int'(cfg_err), 1);
      cfg_write(1, 1'b0, 0, 1'b0);
      check("R8 restored", int'(cfg_err), 0);
      // R8: rank out of range
      cfg_write(4, 1'b1, 5, 1'b1);
      check("R8 rank range", int'(cfg_err), 1);
      cfg_write(4, 1'b1, 1, 1'b1);
      check("R8 restored", int'(cfg_err), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule